// File: doc/BRIEF.md
# Five-Way Insertion Policy Selector With Proportional Counters

This block picks the insertion policy that a shared last-level cache applies when a line fills. Five candidate policies compete. In every group of 128 consecutive sets, five sets are leaders, and each leader always uses its own policy. A demand-miss fill that lands in a leader set adds one to that policy's cost counter. All other sets are followers, and a follower uses whichever policy currently has the smallest cost. When two or more counters share the smallest value, the lowest policy number wins.

A second group of counters keeps one counter for each core. Every fill raises the counter of the core that caused it, whether or not the fill was a demand miss. A core is rated low-miss when four times its counter is below the largest core counter. Two of the insertion policies use this rating.

Both counter groups are proportional. A counter never stays at its ceiling. When an increment would bring any counter to that ceiling, every counter in the same group is shifted right by one bit in that same cycle. As a result, older events lose weight as time passes.

The fill port is a plain event strobe. It has no back-pressure, and the block takes one event on every cycle that the strobe is high. The lookup path is purely combinational, from the set index to the chosen policy. A counter update becomes visible on the outputs in the cycle after its clock edge.

Top module: `ipsel_top`

## Requirements
- R1: After reset every counter is zero. A follower set then reports policy 0 and all four low-miss flags read 0.
- R2: A set is a leader when its index modulo 128 equals 25*p for p in 0..4. For a leader set, policy_sel is p regardless of the counters. Every other set is a follower.
- R3: A fill with ins_valid=1, ins_demand=1 and ins_set on a leader of policy p adds one to counter p. A follower sees the effect from the next cycle.
- R4: A fill with ins_demand=0, or a fill into a follower set, leaves the policy counters unchanged.
- R5: A follower reports the index of the smallest policy counter. A tie goes to the lowest index.
- R6: When an increment brings a policy counter to 4095, all five policy counters take floor(value/2) in that cycle, using the incremented value for the counter that was bumped. A policy counter never holds 4095.
- R7: Every fill with ins_valid=1 adds one to the counter of core ins_core (0..3), whether the fill is demand or not.
- R8: core_low[c] is 1 exactly when 4*counter[c] is less than the largest core counter. A tie at the boundary reads as high, so core_low[c] is 0.
- R9: The core counters follow the rule of R6. Reaching 4095 halves all four counters in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_set | input | 11 | Set whose insertion policy is requested |
| policy_sel | output | 3 | Policy chosen for lookup_set |
| ins_valid | input | 1 | Fill event strobe, one event per cycle |
| ins_demand | input | 1 | 1 when the fill is a demand miss |
| ins_set | input | 11 | Set index of the fill |
| ins_core | input | 2 | Core that caused the fill |
| core_low | output | 4 | Per-core low-miss rating |

## Verification
The leader map is tested on sets from two different constituencies and on near-miss offsets. A winner other than 0 is set up first, so that a leader reporting its fixed policy cannot be mistaken for a follower.

The argmin is stepped through a rising ladder of counts. This shows whether a tie is broken toward the lowest index and whether the minimum moves as expected.

The halving tests push a counter to its ceiling while other counters hold large values. Follow-up fills then make the result differ depending on whether the counters were halved, saturated or wrapped. For the core counters, the boundary is approached one fill at a time, which separates the strict less-than from less-or-equal. Demand fills into follower sets and non-demand fills into leader sets show that neither reaches the policy counters.

// File: rtl/ipsel_pkg.sv
package ipsel_pkg;
  localparam int NPOL  = 5;
  localparam int POL_W = 3;
  typedef logic [POL_W-1:0] pol_t;
endpackage

// File: rtl/ipsel_leader_decode.sv
module ipsel_leader_decode #(
  parameter int SET_W      = 11,
  parameter int CONST_SETS = 128,
  parameter int STRIDE     = 25,
  parameter int NPOL       = 5,
  parameter int POL_W      = 3
) (
  input  logic [SET_W-1:0] set_idx,
  output logic             is_leader,
  output logic [POL_W-1:0] leader_pol
);
  localparam int CONST_W = $clog2(CONST_SETS);

  logic [CONST_W-1:0] offs;
  logic [NPOL-1:0]    hit;

  assign offs = set_idx[CONST_W-1:0];

  for (genvar p = 0; p < NPOL; p++) begin : g_cmp
    assign hit[p] = (offs == CONST_W'(p * STRIDE));
  end

  always_comb begin
    leader_pol = '0;
    for (int p = 0; p < NPOL; p++)
      if (hit[p]) leader_pol = POL_W'(p);
  end

  assign is_leader = |hit;
endmodule

// File: rtl/ipsel_prop_ctr.sv
module ipsel_prop_ctr #(
  parameter int N    = 5,
  parameter int W    = 12,
  parameter int CMAX = 4095
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        inc,
  output logic [N-1:0][W-1:0] cnt
);
  logic [N-1:0][W:0]   sum;
  logic [N-1:0]        at_top;
  logic [N-1:0][W-1:0] nxt;
  logic                halve;

  for (genvar i = 0; i < N; i++) begin : g_sum
    assign sum[i]    = {1'b0, cnt[i]} + (W+1)'(inc[i]);
    assign at_top[i] = (sum[i] >= (W+1)'(CMAX));
  end

  assign halve = |at_top;

  for (genvar i = 0; i < N; i++) begin : g_nxt
    assign nxt[i] = halve ? sum[i][W:1] : sum[i][W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end
endmodule

// File: rtl/ipsel_argmin.sv
module ipsel_argmin #(
  parameter int N     = 5,
  parameter int W     = 12,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0][W-1:0] val,
  output logic [IDX_W-1:0]    idx
);
  logic [W-1:0] best;

  always_comb begin
    best = val[0];
    idx  = '0;
    for (int i = 1; i < N; i++) begin
      if (val[i] < best) begin
        best = val[i];
        idx  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ipsel_core_rate.sv
module ipsel_core_rate #(
  parameter int NCORE = 4,
  parameter int W     = 12
) (
  input  logic [NCORE-1:0][W-1:0] cnt,
  output logic [NCORE-1:0]        low
);
  logic [W-1:0] mx;

  always_comb begin
    mx = '0;
    for (int c = 0; c < NCORE; c++)
      if (cnt[c] > mx) mx = cnt[c];
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_low
    assign low[c] = ({cnt[c], 2'b00} < {2'b00, mx});
  end
endmodule

// File: rtl/ipsel_top.sv
module ipsel_top #(
  parameter int SET_W      = 11,
  parameter int NCORE      = 4,
  parameter int CTR_W      = 12,
  parameter int CMAX       = 4095,
  parameter int CONST_SETS = 128,
  parameter int STRIDE     = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SET_W-1:0]         lookup_set,
  output logic [ipsel_pkg::POL_W-1:0] policy_sel,
  input  logic                     ins_valid,
  input  logic                     ins_demand,
  input  logic [SET_W-1:0]         ins_set,
  input  logic [$clog2(NCORE)-1:0] ins_core,
  output logic [NCORE-1:0]         core_low
);
  import ipsel_pkg::*;

  localparam int CORE_W = $clog2(NCORE);

  logic                    lk_leader, in_leader;
  pol_t                    lk_pol, in_pol, win_idx;
  logic [NPOL-1:0]         pol_inc;
  logic [NCORE-1:0]        core_inc;
  logic [NPOL-1:0][CTR_W-1:0]  pol_cnt_q;
  logic [NCORE-1:0][CTR_W-1:0] core_cnt_q;

  ipsel_leader_decode #(.SET_W(SET_W), .CONST_SETS(CONST_SETS), .STRIDE(STRIDE),
                        .NPOL(NPOL), .POL_W(POL_W)) u_lk_dec (
    .set_idx(lookup_set), .is_leader(lk_leader), .leader_pol(lk_pol));

  ipsel_leader_decode #(.SET_W(SET_W), .CONST_SETS(CONST_SETS), .STRIDE(STRIDE),
                        .NPOL(NPOL), .POL_W(POL_W)) u_in_dec (
    .set_idx(ins_set), .is_leader(in_leader), .leader_pol(in_pol));

  for (genvar p = 0; p < NPOL; p++) begin : g_pinc
    assign pol_inc[p] = ins_valid && ins_demand && in_leader && (in_pol == POL_W'(p));
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_cinc
    assign core_inc[c] = ins_valid && (ins_core == CORE_W'(c));
  end

  ipsel_prop_ctr #(.N(NPOL), .W(CTR_W), .CMAX(CMAX)) u_pol_ctr (
    .clk(clk), .rst_n(rst_n), .inc(pol_inc), .cnt(pol_cnt_q));

  ipsel_prop_ctr #(.N(NCORE), .W(CTR_W), .CMAX(CMAX)) u_core_ctr (
    .clk(clk), .rst_n(rst_n), .inc(core_inc), .cnt(core_cnt_q));

  ipsel_argmin #(.N(NPOL), .W(CTR_W), .IDX_W(POL_W)) u_min (
    .val(pol_cnt_q), .idx(win_idx));

  ipsel_core_rate #(.NCORE(NCORE), .W(CTR_W)) u_rate (
    .cnt(core_cnt_q), .low(core_low));

  assign policy_sel = lk_leader ? lk_pol : win_idx;
endmodule

// File: rtl/ipsel_checker.sv
module ipsel_checker #(
  parameter int SET_W      = 11,
  parameter int NCORE      = 4,
  parameter int CTR_W      = 12,
  parameter int CMAX       = 4095,
  parameter int CONST_SETS = 128,
  parameter int STRIDE     = 25,
  parameter int NPOL       = 5,
  parameter int POL_W      = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [SET_W-1:0]            lookup_set,
  input logic [POL_W-1:0]            policy_sel,
  input logic                        ins_valid,
  input logic [NCORE-1:0]            core_low,
  input logic [POL_W-1:0]            win_idx,
  input logic [NPOL-1:0][CTR_W-1:0]  pol_cnt,
  input logic [NCORE-1:0][CTR_W-1:0] core_cnt
);
  localparam int CONST_W = $clog2(CONST_SETS);

  for (genvar p = 0; p < NPOL; p++) begin : g_lead
    a_r2_leader_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (lookup_set[CONST_W-1:0] == CONST_W'(p * STRIDE)) |-> (policy_sel == POL_W'(p)));

    a_r5_winner_minimal: assert property (@(posedge clk) disable iff (!rst_n)
      pol_cnt[win_idx] <= pol_cnt[p]);

    a_r6_no_policy_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      pol_cnt[p] != CTR_W'(CMAX));
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    a_r9_no_core_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      core_cnt[c] != CTR_W'(CMAX));
  end

  a_r4_idle_keeps_winner: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> $stable(win_idx));

  a_r8_not_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(&core_low));
endmodule

bind ipsel_top ipsel_checker #(
  .SET_W(SET_W), .NCORE(NCORE), .CTR_W(CTR_W), .CMAX(CMAX),
  .CONST_SETS(CONST_SETS), .STRIDE(STRIDE),
  .NPOL(ipsel_pkg::NPOL), .POL_W(ipsel_pkg::POL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lookup_set(lookup_set), .policy_sel(policy_sel),
  .ins_valid(ins_valid), .core_low(core_low), .win_idx(win_idx),
  .pol_cnt(pol_cnt_q), .core_cnt(core_cnt_q)
);

// File: tb/ipsel_top_test.sv
module ipsel_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] lookup_set = '0;
  logic [2:0]  policy_sel;
  logic        ins_valid = 1'b0;
  logic        ins_demand = 1'b0;
  logic [10:0] ins_set = '0;
  logic [1:0]  ins_core = '0;
  logic [3:0]  core_low;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ipsel_top uut (
    .clk(clk), .rst_n(rst_n), .lookup_set(lookup_set), .policy_sel(policy_sel),
    .ins_valid(ins_valid), .ins_demand(ins_demand), .ins_set(ins_set),
    .ins_core(ins_core), .core_low(core_low));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ins_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic fill(input int set, input int core, input bit dem, input int n);
    for (int k = 0; k < n; k++) begin
      ins_valid = 1'b1; ins_set = 11'(set); ins_core = 2'(core); ins_demand = dem;
      @(negedge clk);
    end
    ins_valid = 1'b0;
  endtask

  function automatic int leader(input int p);
    return p * 25;
  endfunction

  task automatic follower_is(input string req, input int exp);
    lookup_set = 11'd7; #1;
    check(req, policy_sel, exp);
  endtask

  task automatic t_reset_state();
    do_reset();
    follower_is("R1 follower after reset", 0);
    check("R1 core_low after reset", core_low, 0);
  endtask

  task automatic t_leader_map();
    do_reset();
    fill(leader(0), 0, 1'b1, 1);
    follower_is("R3 single demand fill moves winner", 1);
    for (int p = 0; p < 5; p++) begin
      lookup_set = 11'(leader(p)); #1;
      check("R2 leader set constituency 0", policy_sel, p);
      lookup_set = 11'(1024 + leader(p)); #1;
      check("R2 leader set constituency 8", policy_sel, p);
    end
    lookup_set = 11'd125; #1;
    check("R2 offset 125 is follower", policy_sel, 1);
    lookup_set = 11'd26; #1;
    check("R2 offset 26 is follower", policy_sel, 1);
  endtask

  task automatic t_ignored();
    do_reset();
    fill(leader(0), 1, 1'b0, 3);
    follower_is("R4 non-demand fill into leader ignored", 0);
    fill(7, 2, 1'b1, 4);
    fill(1000, 2, 1'b1, 4);
    follower_is("R4 follower-set demand fill ignored", 0);
    fill(128 + leader(0), 0, 1'b1, 1);
    follower_is("R3 leader in second constituency counts", 1);
  endtask

  task automatic t_tie_order();
    do_reset();
    for (int p = 0; p < 4; p++) begin
      fill(leader(p), 0, 1'b1, 1);
      follower_is("R5 ladder step", p + 1);
    end
    fill(leader(4), 0, 1'b1, 1);
    follower_is("R5 all equal picks lowest", 0);
    fill(leader(0), 0, 1'b1, 1);
    fill(leader(1), 0, 1'b1, 1);
    follower_is("R5 tie among 2..4 picks 2", 2);
    fill(leader(3), 0, 1'b1, 2);
    fill(leader(2), 0, 1'b1, 2);
    follower_is("R5 unique minimum 4", 4);
  endtask

  task automatic t_policy_halve();
    do_reset();
    fill(leader(1), 0, 1'b1, 2000);
    fill(leader(0), 0, 1'b1, 4094);
    follower_is("R6 before ceiling", 2);
    fill(leader(0), 0, 1'b1, 1);
    for (int p = 2; p < 5; p++) fill(leader(p), 0, 1'b1, 1001);
    follower_is("R6 halved counts select policy 1", 1);
  endtask

  task automatic t_core_rate();
    do_reset();
    fill(7, 0, 1'b0, 4);
    fill(7, 1, 1'b1, 1);
    check("R7 non-demand fills count for core", core_low, 4'b1100);
    check("R8 equality boundary reads high", core_low[1], 0);
    fill(leader(2), 0, 1'b1, 1);
    check("R8 just below boundary reads low", core_low, 4'b1110);
    fill(7, 3, 1'b0, 2);
    check("R8 core3 at 2 of 5 is high", core_low, 4'b0110);
  endtask

  task automatic t_core_halve();
    do_reset();
    fill(7, 1, 1'b0, 1000);
    fill(7, 0, 1'b0, 4094);
    check("R9 before ceiling", core_low, 4'b1110);
    fill(7, 0, 1'b0, 1);
    fill(7, 1, 1'b0, 11);
    check("R9 halved core1 at 511 low", core_low, 4'b1110);
    fill(7, 1, 1'b0, 1);
    check("R9 halved core1 at 512 high", core_low, 4'b1100);
  endtask

  initial begin
    #1_200_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_leader_map();
    t_ignored();
    t_tie_order();
    t_policy_halve();
    t_core_rate();
    t_core_halve();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule